// File: doc/BRIEF.md
# SIMD Pixel Pack and Merge Unit

This block is a formatting datapath for 64-bit packed pixel words. An operation select chooses one of five conversions: signed 16-bit lanes packed to unsigned bytes, signed 32-bit words packed to bytes and spliced into a byte-shifted copy of the first operand, signed 32-bit fixed-point words saturated to 16-bit lanes, bytes widened to 16-bit fixed point, and byte interleave of two 32-bit words. The three pack conversions scale each lane left by a field of an 8-bit status input before a fixed right shift and a clamp.

All arithmetic is combinational. The result is captured in an output register when the input strobe is high, and a done strobe follows one cycle after each input strobe. Operations with a narrow result fill only the low 32 bits and drive the upper half to zero.

Top module: `pixfmt_unit`

## Requirements
- R1: op_sel 0 (lane pack): each signed 16-bit lane i of src_b is shifted left by status[6:3], arithmetically shifted right by 7, and written to result byte i; status bit 7 has no effect on this operation.
- R2: In op_sel 0 each lane value is clamped to 0..255, so negative lanes give 0x00 and lanes above 255 give 0xFF, with no overflow of the left shift for any scale.
- R3: op_sel 1 (word pack): result bits [31:8] equal src_a[23:0] and result bits [63:40] equal src_a[55:32] (src_a shifted left by 8 with the low byte of each 32-bit word cleared).
- R4: In op_sel 1 each signed 32-bit word j of src_b is shifted left by status[7:3], arithmetically shifted right by 23, clamped to 0..255 and written to bits [32j+7:32j].
- R5: op_sel 2 (fixed pack): each signed 32-bit word j of src_b is shifted left by status[7:3], arithmetically shifted right by 16, saturated to -32768..32767 and written to bits [16j+15:16j].
- R6: op_sel 3 (expand): byte i of src_b[31:0] is written to bits [16i+11:16i+4] with zeros in the other bits of that 16-bit lane; src_a and src_b[63:32] have no effect.
- R7: op_sel 4 (merge): result byte 2i is byte i of src_b and result byte 2i+1 is byte i of src_a, for i = 0..3.
- R8: For op_sel 0 and 2, result bits [63:32] are zero.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high; result changes only after a cycle with in_valid high and holds otherwise.
- R10: While rst is high at a clock edge, result and out_valid become zero.
- R11: op_sel values 5, 6 and 7 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid; load the result register |
| op_sel | input | 3 | Operation select (0..4, others give zero) |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| status | input | 8 | Status word; scale in bits [6:3] or [7:3] |
| out_valid | output | 1 | Done strobe, one cycle after in_valid |
| result | output | 64 | Registered result |

## Verification
The assertions assume that op_sel, src_a, src_b and status are stable across the clock edge at which in_valid is sampled, and that in_valid is a clean level with no meaning during reset. The stimulus changes inputs only on the falling clock edge, holds rst high for several cycles at the start, and keeps driving random operands and selects during idle cycles so that the hold checks see inputs that would change the result if they were wrongly captured. Directed vectors place lanes at the clamp limits with the largest scales so the widened intermediates are exercised.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  typedef enum logic [2:0] {
    OP_PACK16  = 3'd0,
    OP_PACKWRD = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pix_op_e;

  localparam int BYTE_W   = 8;
  localparam int LANE_W   = 16;
  localparam int WORD_W   = 32;
  localparam int SCL_LSB  = 3;
  localparam int SCL16_W  = 4;
  localparam int SCL32_W  = 5;
endpackage

// File: rtl/pixfmt_lane_clamp.sv
// One signed lane: widen, scale left, fixed right shift, clamp, truncate.
module pixfmt_lane_clamp #(
  parameter int IN_W            = 16,
  parameter int SCL_W           = 4,
  parameter int POST_SHR        = 7,
  parameter int signed CLAMP_LO = 0,
  parameter int signed CLAMP_HI = 255,
  parameter int OUT_W           = 8
) (
  input  logic [IN_W-1:0]  lane_in,
  input  logic [SCL_W-1:0] scale,
  output logic [OUT_W-1:0] lane_out
);
  // Wide enough that the largest left shift cannot overflow.
  localparam int EXT_W = IN_W + (1 << SCL_W);

  logic signed [EXT_W-1:0] ext_v, shl_v, shr_v, lo_v, hi_v, sat_v;

  assign ext_v = EXT_W'($signed(lane_in));
  assign shl_v = ext_v <<< scale;
  assign shr_v = shl_v >>> POST_SHR;
  assign lo_v  = EXT_W'(CLAMP_LO);
  assign hi_v  = EXT_W'(CLAMP_HI);

  always_comb begin
    if (shr_v < lo_v)      sat_v = lo_v;
    else if (shr_v > hi_v) sat_v = hi_v;
    else                   sat_v = shr_v;
  end

  assign lane_out = sat_v[OUT_W-1:0];
endmodule

// File: rtl/pixfmt_spread.sv
// Byte widening and byte interleave of the low halves of the operands.
module pixfmt_spread #(
  parameter int HALF_W = 32,
  parameter int BYTE_W = 8,
  parameter int GUARD  = 4
) (
  input  logic [HALF_W-1:0]   half_a,
  input  logic [HALF_W-1:0]   half_b,
  output logic [2*HALF_W-1:0] expand_out,
  output logic [2*HALF_W-1:0] merge_out
);
  localparam int NBYTE = HALF_W / BYTE_W;
  localparam int SLOT  = 2 * BYTE_W;
  localparam int TOP_G = SLOT - BYTE_W - GUARD;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign expand_out[i*SLOT +: SLOT] =
      {{TOP_G{1'b0}}, half_b[i*BYTE_W +: BYTE_W], {GUARD{1'b0}}};
    assign merge_out[i*SLOT +: SLOT] =
      {half_a[i*BYTE_W +: BYTE_W], half_b[i*BYTE_W +: BYTE_W]};
  end
endmodule

// File: rtl/pixfmt_unit.sv
module pixfmt_unit
  import pixfmt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [STAT_W-1:0] status,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;
  localparam int N_LANE = DATA_W / LANE_W;
  localparam int N_WORD = DATA_W / WORD_W;
  localparam int KEEP_W = WORD_W - BYTE_W;

  logic [SCL16_W-1:0] scale16;
  logic [SCL32_W-1:0] scale32;
  logic [HALF_W-1:0]  pack16_res;
  logic [HALF_W-1:0]  packfix_res;
  logic [DATA_W-1:0]  packwrd_res;
  logic [DATA_W-1:0]  expand_res;
  logic [DATA_W-1:0]  merge_res;
  logic [DATA_W-1:0]  next_res;

  assign scale16 = status[SCL_LSB +: SCL16_W];
  assign scale32 = status[SCL_LSB +: SCL32_W];

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    pixfmt_lane_clamp #(
      .IN_W(LANE_W), .SCL_W(SCL16_W), .POST_SHR(7),
      .CLAMP_LO(0), .CLAMP_HI(255), .OUT_W(BYTE_W)
    ) u_p16 (
      .lane_in (src_b[i*LANE_W +: LANE_W]),
      .scale   (scale16),
      .lane_out(pack16_res[i*BYTE_W +: BYTE_W])
    );
  end

  for (genvar j = 0; j < N_WORD; j++) begin : g_word
    logic [BYTE_W-1:0] wbyte;
    pixfmt_lane_clamp #(
      .IN_W(WORD_W), .SCL_W(SCL32_W), .POST_SHR(23),
      .CLAMP_LO(0), .CLAMP_HI(255), .OUT_W(BYTE_W)
    ) u_pw (
      .lane_in (src_b[j*WORD_W +: WORD_W]),
      .scale   (scale32),
      .lane_out(wbyte)
    );
    pixfmt_lane_clamp #(
      .IN_W(WORD_W), .SCL_W(SCL32_W), .POST_SHR(16),
      .CLAMP_LO(-32768), .CLAMP_HI(32767), .OUT_W(LANE_W)
    ) u_pf (
      .lane_in (src_b[j*WORD_W +: WORD_W]),
      .scale   (scale32),
      .lane_out(packfix_res[j*LANE_W +: LANE_W])
    );
    // Byte-shifted copy of src_a with this word's low byte replaced.
    assign packwrd_res[j*WORD_W +: WORD_W] = {src_a[j*WORD_W +: KEEP_W], wbyte};
  end

  pixfmt_spread #(.HALF_W(HALF_W), .BYTE_W(BYTE_W), .GUARD(4)) u_spread (
    .half_a    (src_a[HALF_W-1:0]),
    .half_b    (src_b[HALF_W-1:0]),
    .expand_out(expand_res),
    .merge_out (merge_res)
  );

  always_comb begin
    case (op_sel)
      OP_PACK16:  next_res = {{HALF_W{1'b0}}, pack16_res};
      OP_PACKWRD: next_res = packwrd_res;
      OP_PACKFIX: next_res = {{HALF_W{1'b0}}, packfix_res};
      OP_EXPAND:  next_res = expand_res;
      OP_MERGE:   next_res = merge_res;
      default:    next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R9
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R8
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == OP_PACK16 || op_sel == OP_PACKFIX))
      |=> result[DATA_W-1:HALF_W] == '0);
  // R7
  merge_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_MERGE)
      |=> result[2*BYTE_W-1:0] == {$past(src_a[BYTE_W-1:0]), $past(src_b[BYTE_W-1:0])});
  // R6
  expand_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_EXPAND)
      |=> (result[3:0] == 4'h0 && result[LANE_W-1:LANE_W-4] == 4'h0));
  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel > 3'd4) |=> result == '0);
endmodule

// File: tb/tb_pixfmt_unit.sv
module tb_pixfmt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [7:0]  status = '0;
  logic        out_valid;
  logic [63:0] result;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string cur_tag = "R10";
  string exp_tag = "R10";
  logic        exp_v = 1'b0;
  logic [63:0] exp_r = '0;
  bit          primed = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pixfmt_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .status(status),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a,
                                        logic [63:0] b, logic [7:0] st);
    int s4 = int'(st[6:3]);
    int s5 = int'(st[7:3]);
    longint v;
    logic [63:0] o = '0;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
        v = longint'($signed(b[16*i +: 16]));
        v = clampv((v << s4) >>> 7, 0, 255);
        o[8*i +: 8] = v[7:0];
      end
      3'd1: begin
        o = (a << 8) & 64'hFFFF_FF00_FFFF_FF00;
        for (int j = 0; j < 2; j++) begin
          v = longint'($signed(b[32*j +: 32]));
          v = clampv((v << s5) >>> 23, 0, 255);
          o[32*j +: 8] = v[7:0];
        end
      end
      3'd2: for (int j = 0; j < 2; j++) begin
        v = longint'($signed(b[32*j +: 32]));
        v = clampv((v << s5) >>> 16, -32768, 32767);
        o[16*j +: 16] = v[15:0];
      end
      3'd3: for (int i = 0; i < 4; i++) o[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
      3'd4: for (int i = 0; i < 4; i++) begin
        o[16*i +: 8]     = b[8*i +: 8];
        o[16*i + 8 +: 8] = a[8*i +: 8];
      end
      default: o = '0;
    endcase
    return o;
  endfunction

  // Reference model, updated on every rising edge.
  always @(posedge clk) begin
    primed <= 1'b1;
    exp_tag <= cur_tag;
    if (rst) begin
      exp_v <= 1'b0;
      exp_r <= '0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) exp_r <= model(op_sel, src_a, src_b, status);
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (primed && !done) begin
      n_chk++;
      if (out_valid !== exp_v) begin
        n_bad++;
        $display("FAIL %s out_valid actual=%0b expected=%0b", exp_tag, out_valid, exp_v);
      end
      n_chk++;
      if (result !== exp_r) begin
        n_bad++;
        $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_r);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic issue(input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [7:0] st, input string tag);
    @(negedge clk);
    cur_tag = tag; in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; status = st;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cur_tag = tag; in_valid = 1'b0;
      op_sel = 3'($urandom_range(0, 7));
      src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; status = 8'($urandom);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state observed by the comparator during these cycles
    rst = 1'b0;
    // R1 scale 2 with status bit 7 set (must be ignored), plus scale 0
    issue(3'd0, 64'h0, 64'h0100_0080_0040_0001, 8'h80 | (8'd2 << 3), "R1");
    issue(3'd0, 64'h0, 64'h7F80_0400_0200_0180, 8'h00, "R1");
    issue(3'd0, 64'h0, 64'h0003_0002_0001_0005, 8'h80 | (8'd15 << 3), "R1");
    // R2 clamp limits at max scale
    issue(3'd0, 64'h0, 64'h8000_7FFF_FFFF_0001, 8'd15 << 3, "R2");
    issue(3'd0, 64'h0, 64'hFF80_00FF_7FFF_8001, 8'h00, "R2");
    // R3 and R4 word pack
    issue(3'd1, 64'h1122_3344_5566_7788, 64'h0000_4000_FFFF_0000, 8'h00, "R3");
    issue(3'd1, 64'hA5A5_5A5A_F00F_0FF0, 64'h7FFF_FFFF_8000_0000, 8'd31 << 3, "R4");
    issue(3'd1, 64'h0, 64'h0000_0001_0000_0003, 8'd23 << 3, "R4");
    issue(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0200_0080_0000, 8'h80, "R4");
    // R5 fixed pack saturation and in-range values
    issue(3'd2, 64'h0, 64'h7FFF_FFFF_8000_0000, 8'd5 << 3, "R5");
    issue(3'd2, 64'h0, 64'h0001_2345_FFFE_0000, 8'h00, "R5");
    issue(3'd2, 64'h0, 64'h0000_0001_FFFF_FFFF, 8'd31 << 3, "R5");
    // R8 upper half zero is checked on all narrow results above
    issue(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0040_0000_FFC0_0000, 8'd1 << 3, "R8");
    // R6 expand: upper half of src_b and src_a must not matter
    issue(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_80FF_017F, 8'hFF, "R6");
    // R7 merge
    issue(3'd4, 64'hFFFF_FFFF_A1B2_C3D4, 64'h0000_0000_1122_3344, 8'h00, "R7");
    // R11 unused selects
    issue(3'd5, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R11");
    issue(3'd6, 64'h1, 64'h1, 8'h00, "R11");
    issue(3'd4, 64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0, 8'h00, "R7");
    issue(3'd7, 64'h1, 64'h1, 8'h00, "R11");
    // R9 hold while idle with changing inputs
    idle(6, "R9");
    issue(3'd3, 64'h0, 64'h0000_0000_0102_0304, 8'h00, "R9");
    idle(3, "R9");
    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      cur_tag = "R9";
      in_valid = 1'($urandom_range(0, 1));
      op_sel = 3'($urandom_range(0, 7));
      src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; status = 8'($urandom);
    end
    idle(2, "R9");
    // R10 reset in the middle of traffic
    issue(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R10");
    @(negedge clk);
    cur_tag = "R10"; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    idle(2, "R10");
    @(negedge clk);
    finish_run();
  end
endmodule